// File: doc/BRIEF.md
# Multiplexed Eight-Digit Seven-Segment Driver

This block lights an eight-digit, common-anode, seven-segment display by time sharing. Only one digit is driven at any moment. A single free-running binary counter steps through the digits quickly enough that all of them appear steady to a viewer. The counter's upper bits choose the digit, and its lower bits set how long that digit stays lit before the next one takes over.

The user supplies three things:

- a hexadecimal word holding one nibble per digit;
- a mask that says which digits may light;
- a mask that says which decimal points are on.

The block turns the chosen nibble into a segment pattern. It drives the anode lines and the cathode lines low when they are active.

All data inputs are plain levels that are sampled continuously, with no handshake. A new value on the word or on either mask shows on the outputs in the same cycle. There is no valid/ready interface because there is nothing to back-pressure. The dwell length is a parameter. Its default of 14 bits gives 16384 cycles per digit, about 163.8 µs at 100 MHz. A full pass over the eight digits then takes 2^17 cycles, about 1.31 ms.

Top module: `segdrv_top`

## Requirements
- R1: A synchronous, active-high reset clears the scan counter. During reset, and in the first cycle after it is released, digit 0 is selected. With enable bit 0 set, the anode output is then 8'hFE.
- R2: Outside reset, the counter advances by one on every clock and wraps from all ones to zero. Each digit index is held for exactly 2^DWELL_W consecutive cycles. The indices run 0, 1, … 7 and then start again at 0.
- R3: When index k is selected and bit k of `digit_en` is 1, only anode bit k is 0 and the other seven are 1. If that enable bit is 0, all anodes are 1. At most one anode is low in any cycle.
- R4: When `digit_en` is all zeros, `anode` is 8'hFF in every cycle.
- R5: `segment[6:0]` shows nibble `hex_word[4k+3:4k]` of the selected digit k, active low, with bit 0 = segment A through bit 6 = segment G. The lit segments for each nibble are:

  | Nibble | Lit segments |
  |---|---|
  | 0 | A–F |
  | 1 | B, C |
  | 2 | A, B, D, E, G |
  | 3 | A, B, C, D, G |
  | 4 | B, C, F, G |
  | 5 | A, C, D, F, G |
  | 6 | A, C, D, E, F, G |
  | 7 | A, B, C |
  | 8 | all seven |
  | 9 | A, B, C, D, F, G |
  | A | A, B, C, E, F, G |
  | b | C, D, E, F, G |
  | C | A, D, E, F |
  | d | B, C, D, E, G |
  | E | A, D, E, F, G |
  | F | A, E, F, G |

- R6: `segment[7]` is the decimal point of the selected digit k. It is 0 (lit) exactly when `dp_mask[k]` is 1.
- R7: The anode and cathode outputs depend combinationally on the current `hex_word`, `digit_en` and `dp_mask`. A change on any of these inputs shows in the same cycle, part way through a dwell period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hex_word | input | 32 | One hex nibble per digit; digit k uses bits [4k+3:4k] |
| digit_en | input | 8 | Per-digit enable, 1 = digit may light |
| dp_mask | input | 8 | Per-digit decimal point, 1 = point lit |
| anode | output | 8 | Active-low digit drives, bit 0 = rightmost digit |
| segment | output | 8 | Active-low cathodes: bit 7 point, bits 6..0 segments G..A |

## Verification
The bench builds the block with DWELL_W set to 2, so each digit lasts four cycles and a full scan takes 32 cycles. With that setting, several complete scans, every wrap from index 7 back to 0, and a reset in the middle of a dwell all fit in a few hundred cycles. At the default width, a single scan would take more than a hundred thousand cycles. The digit count stays at 8, so the anode and nibble selection are exercised across all eight indices. The bench also covers mask and data changes in the middle of a dwell and the fully blanked display.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;

  // Active-low segment pattern, bit 0 = A ... bit 6 = G
  function automatic logic [6:0] hex_to_seg_n(input logic [3:0] nib);
    logic [6:0] lit;
    case (nib)
      4'h0: lit = 7'b0111111;
      4'h1: lit = 7'b0000110;
      4'h2: lit = 7'b1011011;
      4'h3: lit = 7'b1001111;
      4'h4: lit = 7'b1100110;
      4'h5: lit = 7'b1101101;
      4'h6: lit = 7'b1111101;
      4'h7: lit = 7'b0000111;
      4'h8: lit = 7'b1111111;
      4'h9: lit = 7'b1101111;
      4'hA: lit = 7'b1110111;
      4'hB: lit = 7'b1111100;
      4'hC: lit = 7'b0111001;
      4'hD: lit = 7'b1011110;
      4'hE: lit = 7'b1111001;
      default: lit = 7'b1110001;
    endcase
    return ~lit;
  endfunction

endpackage

// File: rtl/segdrv_scan_counter.sv
module segdrv_scan_counter #(
  parameter int DWELL_W = 14,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  output logic [SEL_W-1:0]   sel,
  output logic [DWELL_W-1:0] dwell
);
  localparam int CNT_W = DWELL_W + SEL_W;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign sel   = cnt_q[CNT_W-1 -: SEL_W];
  assign dwell = cnt_q[DWELL_W-1:0];
endmodule

// File: rtl/segdrv_digit_select.sv
module segdrv_digit_select #(
  parameter int NUM_DIGITS = 8,
  parameter int SEL_W      = $clog2(NUM_DIGITS)
) (
  input  logic [SEL_W-1:0]        sel,
  input  logic [4*NUM_DIGITS-1:0] hex_word,
  input  logic [NUM_DIGITS-1:0]   digit_en,
  input  logic [NUM_DIGITS-1:0]   dp_mask,
  output logic [NUM_DIGITS-1:0]   anode_n,
  output logic [3:0]              nibble,
  output logic                    dp_n
);
  logic [3:0] nib_arr [NUM_DIGITS];

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    assign nib_arr[g] = hex_word[4*g +: 4];
    assign anode_n[g] = ~((sel == SEL_W'(g)) & digit_en[g]);
  end

  assign nibble = nib_arr[sel];
  assign dp_n   = ~dp_mask[sel];
endmodule

// File: rtl/segdrv_hex_decoder.sv
module segdrv_hex_decoder
  import segdrv_pkg::*;
(
  input  logic [3:0] nibble,
  output logic [6:0] seg_n
);
  always_comb seg_n = hex_to_seg_n(nibble);
endmodule

// File: rtl/segdrv_top.sv
module segdrv_top #(
  parameter int DWELL_W    = 14,
  parameter int NUM_DIGITS = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [4*NUM_DIGITS-1:0] hex_word,
  input  logic [NUM_DIGITS-1:0]   digit_en,
  input  logic [NUM_DIGITS-1:0]   dp_mask,
  output logic [NUM_DIGITS-1:0]   anode,
  output logic [7:0]              segment
);
  localparam int SEL_W = $clog2(NUM_DIGITS);

  logic [SEL_W-1:0]   digit_sel;
  logic [DWELL_W-1:0] dwell_cnt;
  logic [3:0]         cur_nib;
  logic               cur_dp_n;
  logic [6:0]         cur_seg_n;

  segdrv_scan_counter #(.DWELL_W(DWELL_W), .SEL_W(SEL_W)) u_scan (
    .clk(clk), .rst(rst), .sel(digit_sel), .dwell(dwell_cnt)
  );

  segdrv_digit_select #(.NUM_DIGITS(NUM_DIGITS), .SEL_W(SEL_W)) u_select (
    .sel(digit_sel), .hex_word(hex_word), .digit_en(digit_en),
    .dp_mask(dp_mask), .anode_n(anode), .nibble(cur_nib), .dp_n(cur_dp_n)
  );

  segdrv_hex_decoder u_dec (.nibble(cur_nib), .seg_n(cur_seg_n));

  assign segment = {cur_dp_n, cur_seg_n};
endmodule

// File: rtl/segdrv_checker.sv
module segdrv_checker #(
  parameter int DWELL_W    = 14,
  parameter int NUM_DIGITS = 8,
  parameter int SEL_W      = $clog2(NUM_DIGITS)
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_DIGITS-1:0] digit_en,
  input logic [NUM_DIGITS-1:0] dp_mask,
  input logic [NUM_DIGITS-1:0] anode,
  input logic [7:0]            segment,
  input logic [SEL_W-1:0]      sel,
  input logic [DWELL_W-1:0]    dwell
);
  AST_RESET_DIGIT0: assert property (@(posedge clk) rst |=> (sel == '0)); // R1

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rst && dwell != '1) |=> $stable(sel)); // R2

  AST_ONE_ANODE: assert property (@(posedge clk) disable iff (rst)
    $countones(~anode) <= 1); // R3

  AST_BLANK_ALL: assert property (@(posedge clk) disable iff (rst)
    (digit_en == '0) |-> (anode == '1)); // R4

  AST_POINT_SEL: assert property (@(posedge clk) disable iff (rst)
    segment[7] == !dp_mask[sel]); // R6
endmodule

bind segdrv_top segdrv_checker #(.DWELL_W(DWELL_W), .NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk(clk), .rst(rst), .digit_en(digit_en), .dp_mask(dp_mask),
  .anode(anode), .segment(segment), .sel(digit_sel), .dwell(dwell_cnt)
);

// File: tb/test_segdrv_top.sv
`timescale 1ns/1ps
module test_segdrv_top;
  localparam int DW = 2;
  localparam int PERIOD_CYC = 1 << (DW + 3);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] hex_word = 32'h0;
  logic [7:0]  digit_en = 8'hFF;
  logic [7:0]  dp_mask  = 8'h00;
  logic [7:0]  anode;
  logic [7:0]  segment;

  int total = 0;
  int bad = 0;
  int cnt = 0;
  string tag = "R5";

  segdrv_top #(.DWELL_W(DW)) i_segdrv_top (
    .clk(clk), .rst(rst), .hex_word(hex_word), .digit_en(digit_en),
    .dp_mask(dp_mask), .anode(anode), .segment(segment)
  );

  always #2.5 clk = ~clk;

  function automatic logic [6:0] lit_of(input int v);
    case (v)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F; 10: return 7'h77; 11: return 7'h7C;
      12: return 7'h39; 13: return 7'h5E; 14: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  task automatic check(input string name, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h (t=%0t)", name, got, exp, $time);
    end
  endtask

  // reference scan count
  always @(posedge clk) begin
    if (rst) cnt = 0;
    else     cnt = (cnt + 1) % PERIOD_CYC;
  end

  // compare on every falling edge
  always @(negedge clk) begin
    int k;
    logic [7:0] exp_an;
    k = cnt >> DW;
    exp_an = digit_en[k] ? ~(8'h01 << k) : 8'hFF;
    check({"R2 R3 anode ", tag}, anode, exp_an);
    check({tag, " segments"}, {1'b0, segment[6:0]},
          {1'b0, ~lit_of(int'((hex_word >> (4*k)) & 32'hF))});
    check({"R6 point ", tag}, {7'b0, segment[7]}, {7'b0, ~dp_mask[k]});
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #1;
    cycles(3);
    hex_word = 32'h01234567;
    @(negedge clk);
    check("R1 anode in reset", anode, 8'hFE);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check("R1 anode after release", anode, 8'hFE);
    cycles(2 * PERIOD_CYC);

    hex_word = 32'h89ABCDEF; dp_mask = 8'hA5; digit_en = 8'h5A;
    cycles(2 * PERIOD_CYC);

    digit_en = 8'h00; tag = "R5 R4";
    @(negedge clk);
    check("R4 blank", anode, 8'hFF);
    cycles(PERIOD_CYC + 5);

    tag = "R5 R7";
    digit_en = 8'hFF;
    for (int i = 0; i < 12; i++) begin
      hex_word = {hex_word[26:0], hex_word[31:27]} ^ (32'h9E3779B9 * (i + 1));
      dp_mask  = dp_mask ^ 8'(i * 37 + 3);
      digit_en = digit_en ^ 8'(1 << (i % 8));
      cycles(3);
    end

    tag = "R5 R1";
    @(posedge clk); #1 rst = 1'b1;
    cycles(1);
    rst = 1'b0;
    digit_en = 8'hFF;
    @(negedge clk);
    check("R1 mid-run reset", anode, 8'hFE);
    cycles(2 * PERIOD_CYC);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule